// File: doc/BRIEF.md
# DMA Burst Length Splitter

The splitter sits between a DMA engine and a memory-mapped master port. It accepts one transfer request at a time and breaks it into a sequence of AXI-style burst commands. Each request carries a start address, a length in beats, a read/write flag and a data/descriptor flag. Each emitted command carries a start address, a length in AXI form and a 4-bit cache/request attribute.

A configuration word chooses the burst sizes the splitter may use. It has one enable bit for each power-of-two size from 4 to 256 beats, a policy bit, and one attribute nibble for each of the four transfer classes. With the policy bit clear, every burst is a single beat or exactly one enabled size. With the policy bit set, a burst may be any length up to the largest enabled size. In both policies the splitter picks the longest allowed burst that fits the remaining beats and does not cross a 4 KB page.

The configuration is captured when a request is accepted. Software may therefore rewrite it between requests without disturbing the request in flight. Both interfaces use valid/ready handshakes.

Top module: `dma_burst_splitter`

## Requirements
- R1: After reset, `cmd_valid` is 0 and `req_ready` is 1.
- R2: With `cfg_any_len` = 0, every burst is 1 beat or a size 4<<i whose enable bit `cfg_size_en[i]` is 1 (bit 0 = 4 beats through bit 6 = 256 beats).
- R3: With `cfg_any_len` = 1, every burst is no longer than the largest enabled size. When no size is enabled, the limit is 1 beat.
- R4: Each burst is the longest length allowed by the active policy that does not exceed the remaining beats or the room left in the current 4 KB page.
- R5: `cmd_attr` equals `cfg_attr_rd_data` for read/data (`req_write`=0, `req_desc`=0), `cfg_attr_rd_desc` for read/descriptor (0,1), `cfg_attr_wr_data` for write/data (1,0) and `cfg_attr_wr_desc` for write/descriptor (1,1).
- R6: `cmd_len` equals the burst's beat count minus one.
- R7: The first burst starts at `req_addr`. Each later burst starts 8 bytes per beat after the previous one, and the bursts of a request add up to `req_beats`.
- R8: No burst crosses a 4 KB address boundary.
- R9: Configuration changes made after a request is accepted do not affect that request's commands.
- R10: `req_ready` stays 0 while commands of a request are outstanding. It returns to 1 in the cycle after the last command handshake. A zero-length request is accepted and emits no command.
- R11: With the all-zero configuration, only single-beat bursts with attribute 0 are produced.
- R12: While `cmd_valid` is 1 and `cmd_ready` is 0, the command fields stay stable and `cmd_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size_en | input | 7 | Burst size enables; bit i allows 4<<i beats |
| cfg_any_len | input | 1 | 1: any length up to largest enabled size |
| cfg_attr_rd_data | input | 4 | Attribute for data reads |
| cfg_attr_rd_desc | input | 4 | Attribute for descriptor reads |
| cfg_attr_wr_data | input | 4 | Attribute for data writes |
| cfg_attr_wr_desc | input | 4 | Attribute for descriptor writes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | ADDR_W | Start byte address, 8-byte aligned |
| req_beats | input | LEN_W | Transfer length in beats |
| req_write | input | 1 | 1 = write, 0 = read |
| req_desc | input | 1 | 1 = descriptor, 0 = data |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command taken when high with valid |
| cmd_addr | output | ADDR_W | Burst start address |
| cmd_len | output | 8 | Beats minus one |
| cmd_attr | output | 4 | Cache/request attribute |

## Verification
The embedded assertions check on every cycle that no command crosses a page, that each burst length obeys the captured policy and enable mask, that requests are refused while commands are pending, and that stalled commands hold still. The scenarios alone can show optimality, because a legal but shorter burst would pass every property. They also cover address stepping, correct beat totals, attribute selection per class and immunity to mid-request configuration writes. The bench sweeps enable masks, both policies, addresses near page ends and many lengths, and applies intermittent back-pressure.

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BITS  = 12,
  parameter int BEAT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        cfg_size_en,
  input  logic              cfg_any_len,
  input  logic [3:0]        cfg_attr_rd_data,
  input  logic [3:0]        cfg_attr_rd_desc,
  input  logic [3:0]        cfg_attr_wr_data,
  input  logic [3:0]        cfg_attr_wr_desc,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_beats,
  input  logic              req_write,
  input  logic              req_desc,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_len,
  output logic [3:0]        cmd_attr
);
  localparam int NSZ  = 7;
  localparam int RW   = PAGE_BITS - BEAT_SHIFT + 1;
  localparam int BW   = (RW > 9) ? RW : 9;
  localparam int PW   = PAGE_BITS + 2;

  logic              busy;
  logic [NSZ-1:0]    s_en;
  logic              s_any;
  logic [3:0]        s_attr;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  rem;

  logic [BW-1:0]     room, lim, fix_len, max_en, burst;
  logic [3:0]        new_attr;
  logic              last;

  assign room = BW'(1 << (PAGE_BITS - BEAT_SHIFT)) - BW'(addr[PAGE_BITS-1:BEAT_SHIFT]);
  assign lim  = (rem < LEN_W'(room)) ? BW'(rem) : room;

  always_comb begin
    fix_len = BW'(1);
    max_en  = BW'(1);
    for (int i = 0; i < NSZ; i++) begin
      if (s_en[i]) begin
        max_en = BW'(4 << i);
        if (BW'(4 << i) <= lim) fix_len = BW'(4 << i);
      end
    end
  end

  assign burst = s_any ? ((lim < max_en) ? lim : max_en) : fix_len;
  assign last  = (rem == LEN_W'(burst));

  always_comb begin
    case ({req_write, req_desc})
      2'b00:   new_attr = cfg_attr_rd_data;
      2'b01:   new_attr = cfg_attr_rd_desc;
      2'b10:   new_attr = cfg_attr_wr_data;
      default: new_attr = cfg_attr_wr_desc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      s_en   <= '0;
      s_any  <= 1'b0;
      s_attr <= '0;
      addr   <= '0;
      rem    <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        s_en   <= cfg_size_en;
        s_any  <= cfg_any_len;
        s_attr <= new_attr;
        addr   <= req_addr;
        rem    <= req_beats;
        busy   <= (req_beats != '0);
      end
    end else if (cmd_ready) begin
      addr <= addr + (ADDR_W'(burst) << BEAT_SHIFT);
      rem  <= rem - LEN_W'(burst);
      if (last) busy <= 1'b0;
    end
  end

  assign req_ready = !busy;
  assign cmd_valid = busy;
  assign cmd_addr  = addr;
  assign cmd_len   = 8'(burst - BW'(1));
  assign cmd_attr  = s_attr;

  // R8
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((PW'(cmd_addr[PAGE_BITS-1:0]) + ((PW'(cmd_len) + PW'(1)) << BEAT_SHIFT))
                   <= PW'(1 << PAGE_BITS)));

  // R2
  fixed_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !s_any) |-> (cmd_len == 8'd0 ||
      (s_en[0] && cmd_len == 8'd3)  || (s_en[1] && cmd_len == 8'd7)  ||
      (s_en[2] && cmd_len == 8'd15) || (s_en[3] && cmd_len == 8'd31) ||
      (s_en[4] && cmd_len == 8'd63) || (s_en[5] && cmd_len == 8'd127) ||
      (s_en[6] && cmd_len == 8'd255)));

  // R3
  any_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && s_any && s_en == '0) |-> cmd_len == 8'd0);

  // R10
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                   $stable(cmd_len) && $stable(cmd_attr)));
endmodule

// File: tb/dma_burst_splitter_tb.sv
module dma_burst_splitter_tb;
  logic clk = 0, rst_n = 0;
  logic [6:0] cfg_size_en = '0;
  logic cfg_any_len = 0;
  logic [3:0] a_rdd = 0, a_rds = 0, a_wrd = 0, a_wrs = 0;
  logic req_valid = 0, req_ready, req_write = 0, req_desc = 0;
  logic [31:0] req_addr = 0;
  logic [15:0] req_beats = 0;
  logic cmd_valid, cmd_ready = 0;
  logic [31:0] cmd_addr;
  logic [7:0] cmd_len;
  logic [3:0] cmd_attr;
  int compared = 0, mismatched = 0, cyc = 0, stall = 0;

  always #2.5 clk = ~clk;

  dma_burst_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_size_en(cfg_size_en), .cfg_any_len(cfg_any_len),
    .cfg_attr_rd_data(a_rdd), .cfg_attr_rd_desc(a_rds),
    .cfg_attr_wr_data(a_wrd), .cfg_attr_wr_desc(a_wrs),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_beats(req_beats), .req_write(req_write), .req_desc(req_desc),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_attr(cmd_attr));

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_burst(input logic [31:0] a, input int rem,
                                   input logic [6:0] en, input logic anyl);
    int room, lim, top;
    room = (4096 - int'(a % 4096)) / 8;
    lim = (rem < room) ? rem : room;
    if (anyl) begin
      top = 1;
      for (int s = 6; s >= 0; s--) if (en[s] && top == 1) top = 4 << s;
      return (lim < top) ? lim : top;
    end
    for (int s = 6; s >= 0; s--) if (en[s] && (4 << s) <= lim) return 4 << s;
    return 1;
  endfunction

  task automatic do_req(input logic [31:0] a, input int beats, input logic wr,
                        input logic ds, input logic scramble);
    logic [6:0] en = cfg_size_en;
    logic anyl = cfg_any_len;
    logic [3:0] attr;
    int rem = beats, b;
    logic [31:0] ea = a;
    logic checked_ready = 0;
    case ({wr, ds})
      2'b00: attr = a_rdd;
      2'b01: attr = a_rds;
      2'b10: attr = a_wrd;
      default: attr = a_wrs;
    endcase
    @(negedge clk);
    req_valid = 1; req_addr = a; req_beats = 16'(beats); req_write = wr; req_desc = ds;
    @(negedge clk);
    req_valid = 0;
    if (scramble) begin
      cfg_size_en = ~en; cfg_any_len = ~anyl;
      a_rdd = ~a_rdd; a_rds = ~a_rds; a_wrd = ~a_wrd; a_wrs = ~a_wrs;
    end
    while (rem > 0) begin
      cmd_ready = (stall % 3) != 2;
      stall++;
      if (!checked_ready) begin
        check("R10 ready low while busy", req_ready, 0);
        checked_ready = 1;
      end
      if (!cmd_valid) begin
        check("R7 command missing", cmd_valid, 1);
        rem = 0;
      end else if (cmd_ready) begin
        b = exp_burst(ea, rem, en, anyl);
        check(scramble ? "R9 addr" : "R7 addr", cmd_addr, ea);
        check(scramble ? "R9 len" : "R4 R6 len", cmd_len, b - 1);
        check(scramble ? "R9 attr" : "R5 attr", cmd_attr, attr);
        ea += 32'(b * 8);
        rem -= b;
      end
      @(negedge clk);
    end
    cmd_ready = 0;
    check("R10 idle after last", {cmd_valid, req_ready}, 2'b01);
    if (scramble) begin
      cfg_size_en = en; cfg_any_len = anyl;
      a_rdd = ~a_rdd; a_rds = ~a_rds; a_wrd = ~a_wrd; a_wrs = ~a_wrs;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [6:0] ens [6] = '{7'h00, 7'h01, 7'h05, 7'h7F, 7'h42, 7'h10};
    logic [31:0] addrs [5] = '{32'h0, 32'hFE0, 32'hFF8, 32'h1F00, 32'h2808};
    int lens [7] = '{0, 1, 3, 5, 17, 100, 300};
    int k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset outputs", {cmd_valid, req_ready}, 2'b01);
    // R11: all-zero configuration
    do_req(32'h100, 6, 0, 0, 0);
    do_req(32'hFF0, 5, 1, 1, 0);
    a_rdd = 4'h3; a_rds = 4'h5; a_wrd = 4'hA; a_wrs = 4'hC;
    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 6; e++)
        for (int ai = 0; ai < 5; ai++)
          for (int li = 0; li < 7; li++) begin
            cfg_any_len = m[0]; cfg_size_en = ens[e];
            do_req(addrs[ai], lens[li], k[1], k[0], 0);
            k++;
          end
    // R9: configuration rewritten mid-request
    cfg_size_en = 7'h06; cfg_any_len = 0;
    do_req(32'hF00, 90, 1, 0, 1);
    cfg_size_en = 7'h20; cfg_any_len = 1;
    do_req(32'h3E8, 200, 0, 1, 1);
    // R8: page-end with full enables in both policies
    cfg_size_en = 7'h7F; cfg_any_len = 0;
    do_req(32'h5FF8, 600, 0, 0, 0);
    cfg_any_len = 1;
    do_req(32'h5FF8, 600, 1, 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule